// File: doc/BRIEF.md
# Video Memory Plane Access Steering

This block sits between a CPU memory bus and a video memory made of four byte-wide planes. Each CPU memory cycle is decoded into a plane-level access. The block works out whether the address lies inside the selected CPU window, which planes a write reaches, which plane a read comes from, and the byte offset inside the plane. It holds a small set of sequencer registers and graphics-controller registers. Each bank is written through its own index port and data port: an index write picks the register, and a data write stores into it.

The sequencer side controls writes. It holds the per-plane write mask, the chain-4 mode and the sequencer odd/even mode. The graphics-controller side controls reads and the window. It holds the read-plane select, its own odd/even mode and the window select. The two odd/even controls are independent, so software has to program both to match. The sequencer reset register also gates the display fetch port. CPU memory cycles are combinational from the ports. Register writes take effect at the next clock edge.

Top module: `plane_steer`

## Requirements
- R1: After reset the configuration is as follows. The write mask is planes 0 and 1. Sequencer odd/even is on, chain-4 is off and graphics odd/even is on. The read plane is 0, the window is 0xB8000 (32K) and the display fetch is enabled.
- R2: The window select is bits 3:2 of graphics data index 6. The codes are 00 = 0xA0000 for 128K, 01 = 0xA0000 for 64K, 10 = 0xB0000 for 64K and 11 = 0xB8000 for 32K. Outside the window there is no plane write and cpuRdData is 0xFF. The window offset is the CPU address minus the base. It is taken modulo 64K as a plane offset.
- R3: With chain-4 off and sequencer odd/even off, a write enables every plane whose bit is set in the write mask (sequencer index 2, bit p = plane p). planeAddr is the window offset.
- R4: With sequencer odd/even on (sequencer index 4 bit 2 = 0) and chain-4 off, a write goes only to even planes for an even offset and to odd planes for an odd offset, still gated by the mask. planeAddr is the offset shifted right by one.
- R5: With chain-4 on (sequencer index 4 bit 3 = 1), chain-4 overrides odd/even. A write goes only to plane offset[1:0], gated by the mask. planeAddr is the offset shifted right by two.
- R6: With chain-4 off and graphics odd/even off, a read returns the plane named by graphics index 4 bits 1:0, with planeAddr equal to the offset.
- R7: With graphics odd/even on (graphics index 5 bit 4) and chain-4 off, a read returns plane {readSel[1], offset[0]}, with planeAddr equal to the offset shifted right by one.
- R8: With chain-4 on, a read returns plane offset[1:0], with planeAddr equal to the offset shifted right by two.
- R9: fetchEn is low while either bit 1 (synchronous reset) or bit 0 of sequencer index 0 is 0. Register writes are still accepted during that time.
- R10: A data write goes to the register named by the last index written on its bank. Data written to an index that has no register has no effect.
- R11: planeWrData always equals cpuWrData, and no planeWe bit is set unless cpuWr is high. planeAddr uses write addressing while cpuWr is high and read addressing otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register port write strobe |
| regSel | input | 2 | 0 sequencer index, 1 sequencer data, 2 graphics index, 3 graphics data |
| regData | input | 8 | Register port write data |
| cpuAddr | input | 20 | CPU memory address |
| cpuWrData | input | 8 | CPU write byte |
| cpuWr | input | 1 | CPU memory write strobe |
| cpuRd | input | 1 | CPU memory read strobe |
| planeRdData | input | 32 | Read bytes of planes 3..0, plane p in bits 8p+7:8p |
| planeAddr | output | 16 | Byte offset inside the planes |
| planeWe | output | 4 | Per-plane write enables |
| planeWrData | output | 8 | Byte written to enabled planes |
| cpuRdData | output | 8 | Byte returned to the CPU |
| fetchEn | output | 1 | Display fetch port enable |

## Verification
The assertions assume that cpuWr and cpuRd are never high in the same cycle. They also assume that CPU cycles are judged only at clock edges, since the steering path is combinational. The stimulus changes every input on the falling edge and raises at most one CPU strobe at a time. It also keeps register writes and CPU cycles in separate cycles, so that every access sees a settled configuration.

// File: rtl/plane_steer_pkg.sv
package plane_steer_pkg;
  localparam int NumPlanes = 4;
  localparam int ByteW = 8;

  // Configuration handed from the register control to the datapath
  typedef struct packed {
    logic [NumPlanes-1:0] mapMask;
    logic                 chain4;
    logic                 seqOddEven;
    logic                 gcOddEven;
    logic [1:0]           readSel;
    logic [1:0]           memMap;
    logic                 fetchEn;
  } steerCfg_t;

  localparam logic [7:0] SeqIdxReset = 8'd0;
  localparam logic [7:0] SeqIdxMask  = 8'd2;
  localparam logic [7:0] SeqIdxMode  = 8'd4;
  localparam logic [7:0] GcIdxRead   = 8'd4;
  localparam logic [7:0] GcIdxMode   = 8'd5;
  localparam logic [7:0] GcIdxMisc   = 8'd6;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import plane_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regSel,
  input  logic [7:0] regData,
  output steerCfg_t  cfg
);
  logic [7:0] seqIdx, gcIdx;
  logic [1:0] resetBits;
  logic [NumPlanes-1:0] mapMask;
  logic chain4, seqOeOff, gcOe;
  logic [1:0] readSel, memMap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqIdx    <= '0;
      gcIdx     <= '0;
      resetBits <= 2'b11;
      mapMask   <= NumPlanes'(4'b0011);
      chain4    <= 1'b0;
      seqOeOff  <= 1'b0;
      gcOe      <= 1'b1;
      readSel   <= 2'd0;
      memMap    <= 2'b11;
    end else if (regWr) begin
      unique case (regSel)
        2'd0: seqIdx <= regData;
        2'd1: begin
          if (seqIdx == SeqIdxReset) resetBits <= regData[1:0];
          if (seqIdx == SeqIdxMask)  mapMask   <= regData[NumPlanes-1:0];
          if (seqIdx == SeqIdxMode) begin
            chain4   <= regData[3];
            seqOeOff <= regData[2];
          end
        end
        2'd2: gcIdx <= regData;
        2'd3: begin
          if (gcIdx == GcIdxRead) readSel <= regData[1:0];
          if (gcIdx == GcIdxMode) gcOe    <= regData[4];
          if (gcIdx == GcIdxMisc) memMap  <= regData[3:2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.mapMask    = mapMask;
    cfg.chain4     = chain4;
    cfg.seqOddEven = ~seqOeOff;
    cfg.gcOddEven  = gcOe;
    cfg.readSel    = readSel;
    cfg.memMap     = memMap;
    cfg.fetchEn    = &resetBits;
  end
endmodule

// File: rtl/steer_path.sv
module steer_path
  import plane_steer_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int PLANE_AW = 16
) (
  input  steerCfg_t                    cfg,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [ByteW-1:0]             cpuWrData,
  input  logic                         cpuWr,
  input  logic [NumPlanes*ByteW-1:0]   planeRdData,
  output logic [PLANE_AW-1:0]          planeAddr,
  output logic [NumPlanes-1:0]         planeWe,
  output logic [ByteW-1:0]             planeWrData,
  output logic [ByteW-1:0]             cpuRdData
);
  localparam int OffW = 17;

  logic            inWin;
  logic [OffW-1:0] offset, wrOff, rdOff;
  logic [NumPlanes-1:0] wrSel;
  logic [1:0]      rdPlane;

  // Window decode
  always_comb begin
    unique case (cfg.memMap)
      2'b00: begin inWin = (cpuAddr[19:17] == 3'b101);  offset = cpuAddr[16:0]; end
      2'b01: begin inWin = (cpuAddr[19:16] == 4'hA);    offset = {1'b0, cpuAddr[15:0]}; end
      2'b10: begin inWin = (cpuAddr[19:16] == 4'hB);    offset = {1'b0, cpuAddr[15:0]}; end
      default: begin inWin = (cpuAddr[19:15] == 5'b10111); offset = {2'b00, cpuAddr[14:0]}; end
    endcase
  end

  // Plane selection and offset per access direction
  always_comb begin
    if (cfg.chain4) begin
      wrOff   = offset >> 2;
      wrSel   = NumPlanes'(1) << offset[1:0];
    end else if (cfg.seqOddEven) begin
      wrOff   = offset >> 1;
      wrSel   = offset[0] ? NumPlanes'(4'b1010) : NumPlanes'(4'b0101);
    end else begin
      wrOff   = offset;
      wrSel   = '1;
    end
    if (cfg.chain4) begin
      rdOff   = offset >> 2;
      rdPlane = offset[1:0];
    end else if (cfg.gcOddEven) begin
      rdOff   = offset >> 1;
      rdPlane = {cfg.readSel[1], offset[0]};
    end else begin
      rdOff   = offset;
      rdPlane = cfg.readSel;
    end
  end

  for (genvar p = 0; p < NumPlanes; p++) begin : g_we
    assign planeWe[p] = cpuWr & inWin & cfg.mapMask[p] & wrSel[p];
  end

  assign planeAddr   = cpuWr ? wrOff[PLANE_AW-1:0] : rdOff[PLANE_AW-1:0];
  assign planeWrData = cpuWrData;
  assign cpuRdData   = inWin ? planeRdData[rdPlane*ByteW +: ByteW] : {ByteW{1'b1}};
endmodule

// File: rtl/plane_steer.sv
module plane_steer
  import plane_steer_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PLANE_AW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWr,
  input  logic [1:0]                 regSel,
  input  logic [7:0]                 regData,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [7:0]                 cpuWrData,
  input  logic                       cpuWr,
  input  logic                       cpuRd,
  input  logic [31:0]                planeRdData,
  output logic [PLANE_AW-1:0]        planeAddr,
  output logic [3:0]                 planeWe,
  output logic [7:0]                 planeWrData,
  output logic [7:0]                 cpuRdData,
  output logic                       fetchEn
);
  steerCfg_t cfg;
  logic      rdUnused;

  steer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regData(regData), .cfg(cfg)
  );

  steer_path #(.ADDR_W(ADDR_W), .PLANE_AW(PLANE_AW)) i_path (
    .cfg(cfg), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWr(cpuWr),
    .planeRdData(planeRdData), .planeAddr(planeAddr), .planeWe(planeWe),
    .planeWrData(planeWrData), .cpuRdData(cpuRdData)
  );

  assign fetchEn  = cfg.fetchEn;
  assign rdUnused = cpuRd;
endmodule

// File: rtl/plane_steer_chk.sv
module plane_steer_chk
  import plane_steer_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [1:0]  regSel,
  input logic [19:0] cpuAddr,
  input logic [7:0]  cpuWrData,
  input logic        cpuWr,
  input logic        cpuRd,
  input logic [3:0]  planeWe,
  input logic [7:0]  planeWrData,
  input logic [7:0]  cpuRdData,
  input logic        fetchEn,
  input steerCfg_t   cfg
);
  a_r11_we_needs_wr: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |-> planeWe == 4'b0000);

  a_r11_data_passes: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr |-> planeWrData == cpuWrData);

  a_r3_we_within_mask: assert property (@(posedge clk) disable iff (!rstN)
    (planeWe & ~cfg.mapMask) == 4'b0000);

  a_r4_parity: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cfg.seqOddEven && !cfg.chain4) |->
      (cpuAddr[0] ? (planeWe[0] == 1'b0 && planeWe[2] == 1'b0)
                  : (planeWe[1] == 1'b0 && planeWe[3] == 1'b0)));

  a_r5_single_plane: assert property (@(posedge clk) disable iff (!rstN)
    cfg.chain4 |-> $onehot0(planeWe));

  a_r2_below_window: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr < 20'hA0000) |-> (planeWe == 4'b0000 && cpuRdData == 8'hFF));

  a_r2_above_window: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 20'hC0000 && cpuRd) |-> cpuRdData == 8'hFF);

  a_r9_fetch_changes_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn != $past(fetchEn)) |-> $past(regWr && regSel == 2'd1));
endmodule

bind plane_steer plane_steer_chk i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .cpuAddr(cpuAddr),
  .cpuWrData(cpuWrData), .cpuWr(cpuWr), .cpuRd(cpuRd), .planeWe(planeWe),
  .planeWrData(planeWrData), .cpuRdData(cpuRdData), .fetchEn(fetchEn), .cfg(cfg)
);

// File: tb/test_plane_steer.sv
module test_plane_steer;
  localparam time ClkPeriod = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regData = '0;
  logic [19:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [31:0] planeRdData = 32'h44332211;
  logic [15:0] planeAddr;
  logic [3:0]  planeWe;
  logic [7:0]  planeWrData;
  logic [7:0]  cpuRdData;
  logic        fetchEn;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct {
    logic [3:0]  we;
    logic [15:0] addr;
    bit          chkAddr;
    logic [7:0]  rd;
    bit          chkRd;
    logic [7:0]  wd;
    logic        fetch;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #(ClkPeriod/2) clk = ~clk;

  plane_steer i_plane_steer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regData(regData),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .planeRdData(planeRdData), .planeAddr(planeAddr), .planeWe(planeWe),
    .planeWrData(planeWrData), .cpuRdData(cpuRdData), .fetchEn(fetchEn)
  );

  task automatic regW(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cpuWr = 1'b0; cpuRd = 1'b0;
    regWr = 1'b1; regSel = sel; regData = d;
  endtask

  task automatic cpuOp(input logic wr, input logic rd, input logic [19:0] a,
                       input logic [7:0] d, input logic [3:0] eWe,
                       input logic [15:0] eAddr, input bit cA,
                       input logic [7:0] eRd, input bit cR,
                       input logic eFetch, input string tag);
    expItem_t it;
    @(negedge clk);
    regWr = 1'b0;
    cpuWr = wr; cpuRd = rd; cpuAddr = a; cpuWrData = d;
    it.we = eWe; it.addr = eAddr; it.chkAddr = cA; it.rd = eRd; it.chkRd = cR;
    it.wd = d; it.fetch = eFetch; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares one queued item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() != 0) begin
        expItem_t it;
        bit bad;
        it = sbq.pop_front();
        checks++;
        bad = (planeWe !== it.we) || (planeWrData !== it.wd) || (fetchEn !== it.fetch)
              || (it.chkAddr && planeAddr !== it.addr) || (it.chkRd && cpuRdData !== it.rd);
        if (bad) begin
          fails++;
          $display("FAIL %s: we=%b addr=%h rd=%h wd=%h fetch=%b expected we=%b addr=%h rd=%h wd=%h fetch=%b",
                   it.tag, planeWe, planeAddr, cpuRdData, planeWrData, fetchEn,
                   it.we, it.addr, it.rd, it.wd, it.fetch);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 R4: defaults, odd/even writes into the 0xB8000 window
    cpuOp(1, 0, 20'hB8000, 8'h5A, 4'b0001, 16'h0000, 1, 8'h00, 0, 1, "R1 R4 even write");
    cpuOp(1, 0, 20'hB8003, 8'hA5, 4'b0010, 16'h0001, 1, 8'h00, 0, 1, "R4 odd write");
    // R7: default graphics odd/even read
    cpuOp(0, 1, 20'hB8001, 8'h00, 4'b0000, 16'h0000, 1, 8'h22, 1, 1, "R7 odd read");
    // R2: outside the default window
    cpuOp(1, 0, 20'hA0000, 8'h11, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R2 write outside");
    cpuOp(0, 1, 20'hA0000, 8'h00, 4'b0000, 16'h0000, 0, 8'hFF, 1, 1, "R2 read outside");
    // R9: synchronous reset low
    regW(2'd0, 8'h00); regW(2'd1, 8'h01);
    cpuOp(0, 0, 20'hB8000, 8'h00, 4'b0000, 16'h0000, 0, 8'h00, 0, 0, "R9 sync reset");
    regW(2'd0, 8'h02); regW(2'd1, 8'h04);
    regW(2'd0, 8'h04); regW(2'd1, 8'h07);
    regW(2'd0, 8'h00); regW(2'd1, 8'h03);
    regW(2'd2, 8'h04); regW(2'd3, 8'h02);
    regW(2'd2, 8'h05); regW(2'd3, 8'h00);
    regW(2'd2, 8'h06); regW(2'd3, 8'h00);
    // R3 R6 R2: sequential, 128K window
    cpuOp(1, 0, 20'hA1234, 8'h33, 4'b0100, 16'h1234, 1, 8'h00, 0, 1, "R3 sequential write");
    cpuOp(0, 1, 20'hA0010, 8'h00, 4'b0000, 16'h0010, 1, 8'h33, 1, 1, "R6 sequential read");
    cpuOp(1, 0, 20'hB0005, 8'h44, 4'b0100, 16'h0005, 1, 8'h00, 0, 1, "R2 128K upper half");
    cpuOp(1, 0, 20'h9FFFF, 8'h44, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R2 below 128K");
    cpuOp(0, 1, 20'h9FFFF, 8'h00, 4'b0000, 16'h0000, 0, 8'hFF, 1, 1, "R2 read below");
    // R2: 64K at 0xA0000
    regW(2'd3, 8'h04);
    cpuOp(1, 0, 20'hB0000, 8'h55, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R2 map01 above");
    cpuOp(1, 0, 20'hAFFFF, 8'h55, 4'b0100, 16'hFFFF, 1, 8'h00, 0, 1, "R2 map01 top");
    // R2: 64K at 0xB0000
    regW(2'd3, 8'h08);
    cpuOp(1, 0, 20'hB0000, 8'h66, 4'b0100, 16'h0000, 1, 8'h00, 0, 1, "R2 map10 base");
    cpuOp(1, 0, 20'hAFFFF, 8'h66, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R2 map10 below");
    // R10: unknown indices are ignored
    regW(2'd0, 8'h07); regW(2'd1, 8'hFF);
    cpuOp(1, 0, 20'hB0001, 8'h77, 4'b0100, 16'h0001, 1, 8'h00, 0, 1, "R10 seq index 7");
    regW(2'd2, 8'h09); regW(2'd3, 8'hFF);
    cpuOp(0, 1, 20'hB0001, 8'h00, 4'b0000, 16'h0001, 1, 8'h33, 1, 1, "R10 gc index 9");
    // R5 R8: chain-4
    regW(2'd0, 8'h02); regW(2'd1, 8'h0F);
    regW(2'd0, 8'h04); regW(2'd1, 8'h0E);
    cpuOp(1, 0, 20'hB0006, 8'h88, 4'b0100, 16'h0001, 1, 8'h00, 0, 1, "R5 chain4 write");
    cpuOp(0, 1, 20'hB0007, 8'h00, 4'b0000, 16'h0001, 1, 8'h44, 1, 1, "R8 chain4 read");
    regW(2'd0, 8'h02); regW(2'd1, 8'h0B);
    cpuOp(1, 0, 20'hB0006, 8'h99, 4'b0000, 16'h0001, 1, 8'h00, 0, 1, "R5 chain4 masked");
    // R11: no strobe, no write
    cpuOp(0, 0, 20'hB0004, 8'hEE, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R11 idle");
    // R9: bit 0 low, register writes still accepted
    regW(2'd0, 8'h00); regW(2'd1, 8'h02);
    cpuOp(0, 0, 20'hB0000, 8'h00, 4'b0000, 16'h0000, 0, 8'h00, 0, 0, "R9 bit0 low");
    regW(2'd0, 8'h02); regW(2'd1, 8'h01);
    cpuOp(1, 0, 20'hB0004, 8'hAB, 4'b0001, 16'h0001, 1, 8'h00, 0, 0, "R9 writes during reset");
    regW(2'd0, 8'h00); regW(2'd1, 8'h03);
    cpuOp(0, 0, 20'hB0000, 8'h00, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R9 released");
    // R7: graphics odd/even with read select 3
    regW(2'd0, 8'h04); regW(2'd1, 8'h06);
    regW(2'd2, 8'h05); regW(2'd3, 8'h10);
    regW(2'd2, 8'h04); regW(2'd3, 8'h03);
    cpuOp(0, 1, 20'hB0004, 8'h00, 4'b0000, 16'h0002, 1, 8'h33, 1, 1, "R7 even read sel3");
    cpuOp(0, 1, 20'hB0005, 8'h00, 4'b0000, 16'h0002, 1, 8'h44, 1, 1, "R7 odd read sel3");
    cpuOp(0, 0, 20'h00000, 8'h00, 4'b0000, 16'h0000, 0, 8'h00, 0, 1, "R11 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule